// File: doc/BRIEF.md
# Instruction Dispatch Router

Each cycle this block receives a group of up to `WIDTH` renamed instructions and decides, slot by slot, where each one goes. A squashed instruction is dropped. A load or a store is written into the memory-ordering queue and also into the scheduler queue. A non-speculative instruction is sent down a separate held-back path and flagged as ready to commit. A nop is retired on the spot: it is marked issued, executed and commit-ready and only moves the queue tail. Any other instruction is a plain scheduler insert. The queues are outside the block; the router sees only the number of free scheduler entries and drives one insert enable per slot for each destination.

Every slot that is not squashed takes one scheduler entry. When a slot finds no free entry left, the router stops at that slot for the rest of the cycle. It raises a block request and a stall to the upstream rename stage, and reports the halted slot's index so that the caller can keep that slot and the slots after it for a later cycle. Six wrapping counters record dispatched, squashed, load, store and non-speculative instructions and queue-full events.

Top module: `dispatch_router`

## Requirements
- R1: After a synchronous reset, all six counters read zero.
- R2: When `grp_valid` is low, every per-slot enable, `block_req` and `stall_rename` are low, `next_slot` is 0 and no counter changes.
- R3: A live slot with flag bit 0 (squashed) set raises only `sq_drop`, takes no entry, and is dropped even when no entry is free. It adds one to `cnt_squash`.
- R4: When a live, non-squashed slot finds the count of entries already used in this cycle at or above `iq_free`, it halts dispatch. That slot and every later slot get no enable. `block_req` and `stall_rename` go high, `next_slot` equals the halted slot's index, and `cnt_full` rises by one on the next edge.
- R5: A slot with flag bit 1 (load) raises `iq_ins` and `lsq_load`. Otherwise, a slot with flag bit 2 (store) raises `iq_ins` and `lsq_store`.
- R6: A slot with flag bit 3 (non-speculative), and neither load nor store, raises only `nonspec_ins` and `commit_ok`.
- R7: A slot with flag bit 4 (nop), and none of bits 0 to 3, raises only `nop_done` and `commit_ok`.
- R8: A slot with no flag set raises only `iq_ins`.
- R9: Classification follows this priority: squashed, then full, then load, store, non-speculative, nop, and finally plain. At most one of `sq_drop`, `iq_ins`, `nonspec_ins`, `nop_done` is high per slot.
- R10: Slots at index `grp_size` or above get no enable. If no halt occurs, `next_slot` equals `grp_size`.
- R11: Each live, non-squashed, non-halted slot takes exactly one scheduler entry, so at most `iq_free` slots receive an insert, retire or non-speculative enable.
- R12: On each edge, `cnt_disp` adds the number of `iq_ins` bits, and `cnt_load`, `cnt_store` and `cnt_nonspec` add the bits of their enables. All counters wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A group is presented this cycle |
| grp_size | input | IDX_W | Number of occupied slots, starting at slot 0 |
| slot_flags | input | 5*WIDTH | Per slot: bit0 squashed, bit1 load, bit2 store, bit3 non-speculative, bit4 nop |
| iq_free | input | FREE_W | Free scheduler entries at cycle start |
| iq_ins | output | WIDTH | Scheduler insert enable per slot |
| lsq_load | output | WIDTH | Memory-queue load insert per slot |
| lsq_store | output | WIDTH | Memory-queue store insert per slot |
| nonspec_ins | output | WIDTH | Non-speculative path insert per slot |
| nop_done | output | WIDTH | Nop retired directly, tail advance per slot |
| commit_ok | output | WIDTH | Slot marked ready to commit |
| sq_drop | output | WIDTH | Squashed slot dropped |
| block_req | output | 1 | Dispatch halted on a full queue |
| stall_rename | output | 1 | Stall request to the rename stage |
| next_slot | output | IDX_W | First slot not consumed |
| cnt_disp | output | CNT_W | Dispatched instruction count |
| cnt_squash | output | CNT_W | Squashed-skip count |
| cnt_load | output | CNT_W | Load dispatch count |
| cnt_store | output | CNT_W | Store dispatch count |
| cnt_nonspec | output | CNT_W | Non-speculative dispatch count |
| cnt_full | output | CNT_W | Queue-full event count |

## Verification
The routing enables, `block_req`, `stall_rename` and `next_slot` are combinational, so they are due in the cycle the group is presented. The bench drives each group on a falling edge and samples these outputs two nanoseconds later, well before the next rising edge. The counters change one edge later. They are sampled one nanosecond after that rising edge and compared with totals that the bench keeps running from its own per-slot expectations. The sweep covers every combination of eight flag codes in four slots, with free-entry counts from zero to five and varying group sizes and valid levels.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    typedef struct packed {
        logic nop;
        logic nonspec;
        logic store;
        logic load;
        logic squashed;
    } slot_flags_t;

    localparam int FLAG_W = $bits(slot_flags_t);

    typedef enum logic [2:0] {
        RT_IDLE,
        RT_DROP,
        RT_HALT,
        RT_LOAD,
        RT_STORE,
        RT_NONSPEC,
        RT_NOP,
        RT_PLAIN
    } route_e;

    // Priority decision for one slot.
    function automatic route_e pick_route(slot_flags_t f, logic live, logic full);
        route_e r;
        if (!live)            r = RT_IDLE;
        else if (f.squashed)  r = RT_DROP;
        else if (full)        r = RT_HALT;
        else if (f.load)      r = RT_LOAD;
        else if (f.store)     r = RT_STORE;
        else if (f.nonspec)   r = RT_NONSPEC;
        else if (f.nop)       r = RT_NOP;
        else                  r = RT_PLAIN;
        return r;
    endfunction

    function automatic logic takes_entry(route_e r);
        return (r == RT_LOAD) || (r == RT_STORE) || (r == RT_NONSPEC) ||
               (r == RT_NOP) || (r == RT_PLAIN);
    endfunction

    // Population count for vectors up to 32 bits.
    function automatic int unsigned ones32(logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int k = 0; k < 32; k++) n += int'(v[k]);
        return n;
    endfunction

endpackage

// File: rtl/dispatch_slot.sv
module dispatch_slot
    import dispatch_pkg::*;
#(
    parameter int FREE_W = 4
) (
    input  logic              live,
    input  slot_flags_t       flags,
    input  logic [FREE_W-1:0] used_in,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              halted_in,
    output route_e            route,
    output logic [FREE_W-1:0] used_out,
    output logic              halted_out
);
    logic full;

    always_comb begin
        full       = (used_in >= free_cnt);
        route      = pick_route(flags, live && !halted_in, full);
        used_out   = used_in + (takes_entry(route) ? FREE_W'(1) : FREE_W'(0));
        halted_out = halted_in || (route == RT_HALT);
    end
endmodule

// File: rtl/dispatch_tally.sv
module dispatch_tally #(
    parameter int WIDTH = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] iq_ins,
    input  logic [WIDTH-1:0] sq_drop,
    input  logic [WIDTH-1:0] lsq_load,
    input  logic [WIDTH-1:0] lsq_store,
    input  logic [WIDTH-1:0] nonspec_ins,
    input  logic             halt_evt,
    output logic [CNT_W-1:0] cnt_disp,
    output logic [CNT_W-1:0] cnt_squash,
    output logic [CNT_W-1:0] cnt_load,
    output logic [CNT_W-1:0] cnt_store,
    output logic [CNT_W-1:0] cnt_nonspec,
    output logic [CNT_W-1:0] cnt_full
);
    import dispatch_pkg::*;

    localparam int NCNT = 6;

    logic [NCNT-1:0][CNT_W-1:0] inc;
    logic [NCNT-1:0][CNT_W-1:0] acc;

    always_comb begin
        inc[0] = CNT_W'(ones32(32'(iq_ins)));
        inc[1] = CNT_W'(ones32(32'(sq_drop)));
        inc[2] = CNT_W'(ones32(32'(lsq_load)));
        inc[3] = CNT_W'(ones32(32'(lsq_store)));
        inc[4] = CNT_W'(ones32(32'(nonspec_ins)));
        inc[5] = CNT_W'(halt_evt);
    end

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) acc[c] <= '0;
            else     acc[c] <= acc[c] + inc[c];
        end
    end

    assign cnt_disp    = acc[0];
    assign cnt_squash  = acc[1];
    assign cnt_load    = acc[2];
    assign cnt_store   = acc[3];
    assign cnt_nonspec = acc[4];
    assign cnt_full    = acc[5];

    // R4: each halt event advances the full counter by one
    assert_full_event_R4: assert property (@(posedge clk) disable iff (rst)
        halt_evt |=> cnt_full == $past(cnt_full) + CNT_W'(1));

    // R1: counters hold zero in the cycle after reset
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (cnt_disp == '0 && cnt_full == '0 && cnt_squash == '0));

    // R12: an idle cycle leaves the dispatched count unchanged
    assert_disp_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (iq_ins == '0) |=> $stable(cnt_disp));
endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
    import dispatch_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int FREE_W = 4,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(WIDTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    grp_valid,
    input  logic [IDX_W-1:0]        grp_size,
    input  logic [FLAG_W*WIDTH-1:0] slot_flags,
    input  logic [FREE_W-1:0]       iq_free,
    output logic [WIDTH-1:0]        iq_ins,
    output logic [WIDTH-1:0]        lsq_load,
    output logic [WIDTH-1:0]        lsq_store,
    output logic [WIDTH-1:0]        nonspec_ins,
    output logic [WIDTH-1:0]        nop_done,
    output logic [WIDTH-1:0]        commit_ok,
    output logic [WIDTH-1:0]        sq_drop,
    output logic                    block_req,
    output logic                    stall_rename,
    output logic [IDX_W-1:0]        next_slot,
    output logic [CNT_W-1:0]        cnt_disp,
    output logic [CNT_W-1:0]        cnt_squash,
    output logic [CNT_W-1:0]        cnt_load,
    output logic [CNT_W-1:0]        cnt_store,
    output logic [CNT_W-1:0]        cnt_nonspec,
    output logic [CNT_W-1:0]        cnt_full
);
    logic [WIDTH:0][FREE_W-1:0] used_chain;
    logic [WIDTH:0]             halt_chain;
    route_e                     route [WIDTH];

    assign used_chain[0] = '0;
    assign halt_chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        slot_flags_t fl;
        logic        live;

        assign fl   = slot_flags[i*FLAG_W +: FLAG_W];
        assign live = grp_valid && (IDX_W'(i) < grp_size);

        dispatch_slot #(.FREE_W(FREE_W)) u_slot (
            .live      (live),
            .flags     (fl),
            .used_in   (used_chain[i]),
            .free_cnt  (iq_free),
            .halted_in (halt_chain[i]),
            .route     (route[i]),
            .used_out  (used_chain[i+1]),
            .halted_out(halt_chain[i+1])
        );

        always_comb begin
            iq_ins[i]      = (route[i] == RT_LOAD) || (route[i] == RT_STORE) ||
                             (route[i] == RT_PLAIN);
            lsq_load[i]    = (route[i] == RT_LOAD);
            lsq_store[i]   = (route[i] == RT_STORE);
            nonspec_ins[i] = (route[i] == RT_NONSPEC);
            nop_done[i]    = (route[i] == RT_NOP);
            commit_ok[i]   = (route[i] == RT_NONSPEC) || (route[i] == RT_NOP);
            sq_drop[i]     = (route[i] == RT_DROP);
        end

        // R9: one destination class per slot
        assert_one_class_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0({sq_drop[i], iq_ins[i], nonspec_ins[i], nop_done[i]}));

        // R10: slots past the group size stay silent
        assert_beyond_size_R10: assert property (@(posedge clk) disable iff (rst)
            (IDX_W'(i) >= grp_size) |->
            !(sq_drop[i] || iq_ins[i] || nonspec_ins[i] || nop_done[i]));
    end

    always_comb begin
        next_slot = grp_valid ? grp_size : '0;
        for (int k = WIDTH - 1; k >= 0; k--) begin
            if (route[k] == RT_HALT) next_slot = IDX_W'(k);
        end
    end

    assign block_req    = halt_chain[WIDTH];
    assign stall_rename = halt_chain[WIDTH];

    dispatch_tally #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst        (rst),
        .iq_ins     (iq_ins),
        .sq_drop    (sq_drop),
        .lsq_load   (lsq_load),
        .lsq_store  (lsq_store),
        .nonspec_ins(nonspec_ins),
        .halt_evt   (block_req),
        .cnt_disp   (cnt_disp),
        .cnt_squash (cnt_squash),
        .cnt_load   (cnt_load),
        .cnt_store  (cnt_store),
        .cnt_nonspec(cnt_nonspec),
        .cnt_full   (cnt_full)
    );

    // R4: a halted slot lies inside the group
    assert_halt_inside_R4: assert property (@(posedge clk) disable iff (rst)
        block_req |-> (next_slot < grp_size));

    // R11: entries taken never exceed the free count
    assert_capacity_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(iq_ins | nonspec_ins | nop_done) <= int'(iq_free));

    // R5: memory-queue inserts always pair with a scheduler insert
    assert_mem_pair_R5: assert property (@(posedge clk) disable iff (rst)
        ((lsq_load | lsq_store) & ~iq_ins) == '0);

    // R2: no group, no activity
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !grp_valid |-> (!block_req && next_slot == '0 && sq_drop == '0));
endmodule

// File: tb/sim_dispatch_router.sv
module sim_dispatch_router;
    localparam int W = 4;
    localparam int FW = 4;
    localparam int CW = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grp_valid = 1'b0;
    logic [IW-1:0] grp_size = '0;
    logic [5*W-1:0] slot_flags = '0;
    logic [FW-1:0] iq_free = '0;
    logic [W-1:0] iq_ins, lsq_load, lsq_store, nonspec_ins, nop_done, commit_ok, sq_drop;
    logic block_req, stall_rename;
    logic [IW-1:0] next_slot;
    logic [CW-1:0] cnt_disp, cnt_squash, cnt_load, cnt_store, cnt_nonspec, cnt_full;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [W-1:0] e_iq, e_ld, e_st, e_ns, e_nop, e_cc, e_sq;
    logic e_blk;
    logic [IW-1:0] e_next;
    logic [CW-1:0] m_disp, m_sq, m_ld, m_st, m_ns, m_full;

    always #5 clk = ~clk;

    dispatch_router #(.WIDTH(W), .FREE_W(FW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_size(grp_size),
        .slot_flags(slot_flags), .iq_free(iq_free),
        .iq_ins(iq_ins), .lsq_load(lsq_load), .lsq_store(lsq_store),
        .nonspec_ins(nonspec_ins), .nop_done(nop_done), .commit_ok(commit_ok),
        .sq_drop(sq_drop), .block_req(block_req), .stall_rename(stall_rename),
        .next_slot(next_slot), .cnt_disp(cnt_disp), .cnt_squash(cnt_squash),
        .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_nonspec(cnt_nonspec),
        .cnt_full(cnt_full)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Flag code per slot: bit0 squashed, bit1 load, bit2 store, bit3 nonspec, bit4 nop
    function automatic logic [4:0] code_flags(int c);
        case (c)
            0: return 5'h00;
            1: return 5'h01;
            2: return 5'h02;
            3: return 5'h04;
            4: return 5'h08;
            5: return 5'h10;
            6: return 5'h1E;
            default: return 5'h07;
        endcase
    endfunction

    // Expected routing, written from the requirements
    task automatic model();
        int used;
        bit halted;
        e_iq = '0; e_ld = '0; e_st = '0; e_ns = '0; e_nop = '0; e_cc = '0; e_sq = '0;
        e_blk = 1'b0;
        e_next = grp_valid ? grp_size : '0;               // R10, R2
        used = 0;
        halted = 0;
        for (int i = 0; i < W; i++) begin
            logic [4:0] f;
            f = slot_flags[i*5 +: 5];
            if (grp_valid && i < int'(grp_size) && !halted) begin
                if (f[0]) e_sq[i] = 1'b1;                  // R3
                else if (used >= int'(iq_free)) begin      // R4
                    halted = 1; e_blk = 1'b1; e_next = IW'(i);
                end else begin
                    used++;                                // R11
                    if (f[1]) begin e_iq[i] = 1; e_ld[i] = 1; end        // R5
                    else if (f[2]) begin e_iq[i] = 1; e_st[i] = 1; end
                    else if (f[3]) begin e_ns[i] = 1; e_cc[i] = 1; end   // R6
                    else if (f[4]) begin e_nop[i] = 1; e_cc[i] = 1; end  // R7
                    else e_iq[i] = 1;                                    // R8
                end
            end
        end
    endtask

    function automatic int pc(logic [W-1:0] v);
        int n = 0;
        for (int k = 0; k < W; k++) n += int'(v[k]);
        return n;
    endfunction

    task automatic run_group(input bit gv, input int sz, input logic [5*W-1:0] fl, input int fr);
        @(negedge clk);
        grp_valid = gv; grp_size = IW'(sz); slot_flags = fl; iq_free = FW'(fr);
        #2;
        model();
        chk("R9 routing sq_drop (R3)", 32'(sq_drop), 32'(e_sq));
        chk("R5/R8 iq_ins", 32'(iq_ins), 32'(e_iq));
        chk("R5 lsq_load", 32'(lsq_load), 32'(e_ld));
        chk("R5 lsq_store", 32'(lsq_store), 32'(e_st));
        chk("R6 nonspec_ins", 32'(nonspec_ins), 32'(e_ns));
        chk("R7 nop_done", 32'(nop_done), 32'(e_nop));
        chk("R6/R7 commit_ok", 32'(commit_ok), 32'(e_cc));
        chk("R4 block_req", 32'(block_req), 32'(e_blk));
        chk("R4 stall_rename", 32'(stall_rename), 32'(e_blk));
        chk("R4/R10 next_slot", 32'(next_slot), 32'(e_next));
        m_disp += CW'(pc(e_iq)); m_sq += CW'(pc(e_sq)); m_ld += CW'(pc(e_ld));
        m_st += CW'(pc(e_st)); m_ns += CW'(pc(e_ns)); m_full += CW'(e_blk);
        @(posedge clk);
        #1;
        chk("R12 cnt_disp", 32'(cnt_disp), 32'(m_disp));
        chk("R3 cnt_squash", 32'(cnt_squash), 32'(m_sq));
        chk("R12 cnt_load", 32'(cnt_load), 32'(m_ld));
        chk("R12 cnt_store", 32'(cnt_store), 32'(m_st));
        chk("R12 cnt_nonspec", 32'(cnt_nonspec), 32'(m_ns));
        chk("R4 cnt_full", 32'(cnt_full), 32'(m_full));
    endtask

    initial begin
        m_disp = '0; m_sq = '0; m_ld = '0; m_st = '0; m_ns = '0; m_full = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: counters clear after reset
        chk("R1 cnt_disp", 32'(cnt_disp), 0);
        chk("R1 cnt_full", 32'(cnt_full), 0);
        chk("R1 cnt_squash", 32'(cnt_squash), 0);
        // R2: idle group with content on the other inputs
        run_group(0, 4, 20'hFFFFF, 3);
        // R3: all squashed with no free entry
        run_group(1, 4, {4{5'h01}}, 0);
        // R4: plain group, two free entries halts at slot 2
        run_group(1, 4, 20'h0, 2);
        // R10: short group
        run_group(1, 2, 20'h0, 9);
        // Sweep over all flag codes, free counts, sizes and valid levels
        for (int p = 0; p < 4096; p++) begin
            for (int fr = 0; fr < 6; fr++) begin
                logic [5*W-1:0] fl;
                for (int s = 0; s < W; s++) fl[s*5 +: 5] = code_flags((p >> (3*s)) & 7);
                run_group(((p + fr) % 7) != 0, (p + fr) % 5, fl, fr);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 199000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule